// File: doc/BRIEF.md
# Pattern-Synchronous Trigger Generator

This block drives a single trigger bit for an error-detector front end that handles one bit per clock cycle. It has two operating modes. In pattern mode it watches a start strobe that marks the first bit of every repetition of the reference pattern. It fires one pulse on every fourth repetition, and that pulse stays high for half the pattern length. In divided-clock mode it ignores the strobe and produces a 50% duty-cycle square wave at the bit clock divided by one of seven ratios. One of those ratios, 40, is not a power of two.

The mode and the ratio are static configuration inputs. Any change to either one restarts the block from a clean state: the trigger is forced low and every counter begins again. Downstream logic therefore sees a predictable phase after reconfiguration. The trigger comes straight from a flop, so it moves exactly one cycle after the event that causes it.

Top module: `pattrig_top`

## Requirements
- R1: In pattern mode (mode_sel = 0) a repetition counter advances modulo 4 on every start strobe. The counter is zero on the first strobe after reset or after a configuration change. Only a strobe seen while the counter is zero starts a pulse. The other three strobes in each group of four leave the output low.
- R2: A qualifying strobe sampled on a clock edge makes trig_o high after that same edge, so trig_o is high from the following cycle onward.
- R3: The pattern-mode pulse stays high for floor(pat_len/2) cycles, with a minimum of 1 cycle. The width uses pat_len as sampled with the qualifying strobe.
- R4: In divided-clock mode (mode_sel = 1) with half-ratio H, trig_o is a square wave. It is low for the H cycles that start with the edge on which the configuration takes effect, then high for H cycles, and so on.
- R5: The ratio_sel code sets the divide ratio N, where H = N/2. The codes are 0→4, 1→8, 2→16, 3→32, 4→40, 5→64, 6→128 and 7→128.
- R6: In divided-clock mode the start strobe has no effect on trig_o.
- R7: A change of mode_sel or ratio_sel forces trig_o low after the next edge and restarts all counters. A pulse in progress is cut short, and the first strobe after the change qualifies.
- R8: While rst_n is low, trig_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = pattern mode, 1 = divided-clock mode |
| ratio_sel | input | 3 | Divide-ratio code (see R5) |
| start_i | input | 1 | One-cycle strobe at the first bit of each pattern repetition |
| pat_len | input | LEN_W (16) | Pattern length in bits |
| trig_o | output | 1 | Registered trigger output |

## Verification
The bench builds the block with its defaults: a 16-bit length field and a modulo-4 repetition count. With these settings every one of the eight ratio codes can be swept over three full output periods, with strobes injected throughout. Pattern lengths run from 1 and 2, where the width floor applies, through odd values, up to 1000. Each length is run over nine repetitions, so the bench checks every cycle against a position computed arithmetically inside the repetition. A separate sequence changes the ratio in the middle of a pulse. It shows the early clear and shows that the repetition count restarts.

// File: rtl/pattrig_pkg.sv
package pattrig_pkg;

   localparam int HALF_W = 7;

   typedef enum logic {
      TRG_PATTERN = 1'b0,
      TRG_DIVCLK  = 1'b1
   } trg_mode_e;

   // half of the divide ratio selected by a 3-bit code
   function automatic logic [HALF_W-1:0] half_of(input logic [2:0] code);
      logic [HALF_W-1:0] h;
      case (code)
         3'd0:    h = 7'd2;
         3'd1:    h = 7'd4;
         3'd2:    h = 7'd8;
         3'd3:    h = 7'd16;
         3'd4:    h = 7'd20;
         3'd5:    h = 7'd32;
         default: h = 7'd64;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/pattrig_cfg_watch.sv
module pattrig_cfg_watch
   import pattrig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_sel,
   input  logic [2:0] ratio_sel,
   output trg_mode_e  mode_q,
   output logic [2:0] ratio_q,
   output logic       clr
);

   assign clr = (trg_mode_e'(mode_sel) != mode_q) || (ratio_sel != ratio_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= TRG_PATTERN;
         ratio_q <= 3'd0;
      end else if (clr) begin
         mode_q  <= trg_mode_e'(mode_sel);
         ratio_q <= ratio_sel;
      end
   end

   // the latched configuration follows the inputs one edge after a change (R7)
   p_cfg_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ratio_q == $past(ratio_sel)));

endmodule

// File: rtl/pattrig_pulse.sv
module pattrig_pulse #(
   parameter int LEN_W = 16,
   parameter int REPS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             start,
   input  logic [LEN_W-1:0] pat_len,
   output logic             trig_q
);

   localparam int REP_W = (REPS > 1) ? $clog2(REPS) : 1;

   if (LEN_W < 2) begin : g_bad_len
      $error("pattrig_pulse: LEN_W must be at least 2");
   end
   if (REPS < 1) begin : g_bad_reps
      $error("pattrig_pulse: REPS must be at least 1");
   end

   logic [LEN_W-1:0] half_len;
   logic [LEN_W-1:0] width;
   logic [LEN_W-1:0] wcnt;
   logic             qual;

   assign half_len = pat_len >> 1;
   assign width    = (half_len == '0) ? LEN_W'(1) : half_len;

   if (REPS > 1) begin : g_rep
      logic [REP_W-1:0] rep;
      assign qual = en && start && (rep == '0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             rep <= '0;
         else if (clr || !en)    rep <= '0;
         else if (start) begin
            if (rep == REP_W'(REPS-1)) rep <= '0;
            else                       rep <= rep + REP_W'(1);
         end
      end
   end else begin : g_norep
      assign qual = en && start;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         wcnt   <= '0;
      end else if (clr || !en) begin
         trig_q <= 1'b0;
         wcnt   <= '0;
      end else if (qual) begin
         trig_q <= 1'b1;
         wcnt   <= width - LEN_W'(1);
      end else if (trig_q) begin
         if (wcnt == '0) trig_q <= 1'b0;
         else            wcnt   <= wcnt - LEN_W'(1);
      end
   end

   // a rise is always caused by a strobe on the previous edge (R2)
   p_rise_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_q) |-> $past(start));

   if (REPS > 1) begin : g_width_chk
      logic [LEN_W-1:0] run_cnt;
      logic [LEN_W-1:0] w_exp;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_cnt <= '0;
            w_exp   <= '0;
         end else if (trig_q) begin
            run_cnt <= run_cnt + LEN_W'(1);
         end else begin
            run_cnt <= '0;
            w_exp   <= width;
         end
      end
      // a pulse that ends on its own lasted the computed width (R3)
      p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(trig_q) && !$past(clr) && $past(en)) |-> (run_cnt == w_exp));
   end

endmodule

// File: rtl/pattrig_div.sv
module pattrig_div
   import pattrig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [2:0] code,
   output logic       trig_q
);

   logic [HALF_W-1:0] half;
   logic [HALF_W-1:0] cnt;
   logic              term;

   assign half = half_of(code);
   assign term = (cnt == half - HALF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         trig_q <= 1'b0;
      end else if (clr || !en) begin
         cnt    <= '0;
         trig_q <= 1'b0;
      end else if (term) begin
         cnt    <= '0;
         trig_q <= ~trig_q;
      end else begin
         cnt    <= cnt + HALF_W'(1);
      end
   end

   // the square wave only flips at a half-period boundary (R4)
   p_toggle_at_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(trig_q) && $past(en) && !$past(clr)) |-> ($past(cnt) == $past(half) - HALF_W'(1)));

   // the counter never passes the selected half-ratio (R5)
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |-> (cnt < half));

endmodule

// File: rtl/pattrig_top.sv
module pattrig_top
   import pattrig_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int REPS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_sel,
   input  logic [2:0]       ratio_sel,
   input  logic             start_i,
   input  logic [LEN_W-1:0] pat_len,
   output logic             trig_o
);

   trg_mode_e  mode_q;
   logic [2:0] ratio_q;
   logic       clr;
   logic       pul_q;
   logic       div_q;

   pattrig_cfg_watch i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .ratio_sel (ratio_sel),
      .mode_q    (mode_q),
      .ratio_q   (ratio_q),
      .clr       (clr)
   );

   pattrig_pulse #(.LEN_W(LEN_W), .REPS(REPS)) i_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .en      (mode_q == TRG_PATTERN),
      .start   (start_i),
      .pat_len (pat_len),
      .trig_q  (pul_q)
   );

   pattrig_div i_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .en     (mode_q == TRG_DIVCLK),
      .code   (ratio_q),
      .trig_q (div_q)
   );

   assign trig_o = (mode_q == TRG_DIVCLK) ? div_q : pul_q;

   // a configuration change leaves the output low after the next edge (R7)
   p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !trig_o);

   // reset holds the output low (R8)
   p_reset_low_r8: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || !trig_o) || $past(rst_n));

   // in divided-clock mode the strobe cannot drive the output (R6)
   p_div_ignores_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == TRG_DIVCLK) |-> !pul_q);

endmodule

// File: tb/test_pattrig_top.sv
module test_pattrig_top;

   localparam int LEN_W = 16;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             mode_sel;
   logic [2:0]       ratio_sel;
   logic             start_i;
   logic [LEN_W-1:0] pat_len;
   logic             trig_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pattrig_top #(.LEN_W(LEN_W), .REPS(4)) i_pattrig_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .ratio_sel (ratio_sel),
      .start_i   (start_i),
      .pat_len   (pat_len),
      .trig_o    (trig_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic exp, input string tag);
      n_run++;
      if (trig_o !== exp) begin
         n_fail++;
         $display("FAIL %s: trig_o=%0b expected %0b", tag, trig_o, exp);
      end
   endtask

   function automatic int half_ref(input int code);
      case (code)
         0: return 2;
         1: return 4;
         2: return 8;
         3: return 16;
         4: return 20;
         5: return 32;
         default: return 64;
      endcase
   endfunction

   task automatic run_div(input int code);
      int h;
      h = half_ref(code);
      mode_sel  = 1'b1;
      ratio_sel = code[2:0];
      for (int k = 0; k < 6 * h; k++) begin
         start_i = (k % 3 == 0);
         step();
         chk(((k / h) % 2) == 1, $sformatf("R4/R5/R6 code=%0d k=%0d", code, k));
      end
      start_i = 1'b0;
   endtask

   task automatic run_pat(input int idx, input int len);
      int w;
      int q;
      int r;
      w = (len / 2 == 0) ? 1 : len / 2;
      mode_sel  = 1'b0;
      ratio_sel = idx[2:0];
      pat_len   = LEN_W'(len);
      start_i   = 1'b0;
      step();
      chk(1'b0, $sformatf("R7 config edge len=%0d", len));
      for (int k = 0; k < 9 * len; k++) begin
         start_i = (k % len == 0);
         step();
         q = k / len;
         r = k % len;
         if (q % 4 != 0)
            chk(1'b0, $sformatf("R1 len=%0d k=%0d", len, k));
         else if (r == 0)
            chk(1'b1, $sformatf("R2 len=%0d k=%0d", len, k));
         else
            chk(r < w, $sformatf("R3 len=%0d k=%0d", len, k));
      end
      start_i = 1'b0;
   endtask

   initial begin
      rst_n     = 1'b0;
      mode_sel  = 1'b0;
      ratio_sel = 3'd0;
      start_i   = 1'b0;
      pat_len   = LEN_W'(8);
      step();
      step();
      chk(1'b0, "R8 during reset");
      rst_n = 1'b1;
      step();
      chk(1'b0, "R8 after reset");

      for (int c = 0; c < 8; c++) run_div(c);

      begin
         int lens[7] = '{1, 2, 3, 5, 8, 13, 1000};
         for (int i = 0; i < 7; i++) run_pat(i, lens[i]);
      end

      // mid-pulse reconfiguration
      mode_sel  = 1'b0;
      ratio_sel = 3'd7;
      pat_len   = LEN_W'(8);
      start_i   = 1'b0;
      step();
      chk(1'b0, "R7 config edge");
      start_i = 1'b1;
      step();
      chk(1'b1, "R2 pulse start");
      start_i   = 1'b0;
      ratio_sel = 3'd5;
      step();
      chk(1'b0, "R7 cut short");
      step();
      chk(1'b0, "R7 stays low");
      start_i = 1'b1;
      step();
      chk(1'b1, "R7 repetition count restarted");
      start_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         step();
         chk(1'b1, "R3 width after restart");
      end
      step();
      chk(1'b0, "R3 end after restart");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule